// File: doc/BRIEF.md
# Programmable LCD Timing Generator

This block produces the raster timing for a TFT panel: horizontal and vertical sync, a display-enable window, and the current pixel coordinates inside that window. It runs on the pixel clock. A horizontal counter steps once per pixel position, and a vertical counter steps once per completed line. Every sync pulse and every active window is set by a 32-bit configuration word that holds a start position and an end position. A separate total word sets the line length and the frame length.

The configuration words, the mode bits and the polarity bits are plain inputs. The block copies them into shadow registers in two cases: while reset is held, and at the clock edge that ends a frame. A frame therefore always runs under one consistent set of settings. In serial mode each active pixel position is held for three clocks, one per colour byte, and a phase output marks which byte is being sent.

Top module: `lcd_tgen_top`

## Requirements
- R1: While `rst` is high at a clock edge, every output register clears to zero: `hsync_o`, `vsync_o`, `de_o`, `x_o`, `y_o`, `sub_o` and `pclk_inv_o`. Both counters return to position 0, and the shadow copy of all inputs is loaded.
- R2: In each window word the start position sits in bits 31:16 and the end position in bits 15:0. In `total_i`, bits 31:16 hold the line length in positions and bits 15:0 hold the frame length in lines.
- R3: The unpolarised horizontal sync is active while the horizontal position h satisfies start <= h < end of `hsync_win_i`. A window whose start equals its end never fires.
- R4: The unpolarised vertical sync is active while the line number v satisfies start <= v < end of `vsync_win_i`.
- R5: `de_o` is high when h lies in the `hact_win_i` window and v lies in the `vact_win_i` window. While it is high, `x_o` = h minus the horizontal active start and `y_o` = v minus the vertical active start. While `de_o` is low, `x_o` and `y_o` are 0.
- R6: The horizontal position returns to 0 after position (line length - 1). The line number advances by one at each such wrap and returns to 0 after line (frame length - 1). A length of 0 or 1 wraps at every step.
- R7: With `serial_i` = 1, each horizontal position inside the horizontal active window lasts three clocks, and `sub_o` counts 0, 1, 2 across them while `de_o` is high (0 otherwise). A line then lasts line length + 2 x active width clocks.
- R8: `hsync_o` is the horizontal sync XOR `hsync_inv_i`, and `vsync_o` is the vertical sync XOR `vsync_inv_i`. `pclk_inv_o` carries `pclk_inv_i`. All three use the shadowed values.
- R9: Changes on any configuration or mode input take effect at the first clock after the current frame ends. The frame in progress keeps its old settings.
- R10: Every output is registered. The outputs seen after a clock edge describe the counter position held before that edge. The first edge with `rst` low therefore shows position (0,0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset; also loads the shadow registers |
| hsync_win_i | input | 32 | Horizontal sync window, start in 31:16, end in 15:0 |
| vsync_win_i | input | 32 | Vertical sync window in lines |
| hact_win_i | input | 32 | Horizontal active window in positions |
| vact_win_i | input | 32 | Vertical active window in lines |
| total_i | input | 32 | Line length in 31:16, frame length in 15:0 |
| serial_i | input | 1 | Three clocks per active pixel (byte-serial RGB) |
| pclk_inv_i | input | 1 | Request inverted pixel clock at the panel |
| hsync_inv_i | input | 1 | Invert horizontal sync |
| vsync_inv_i | input | 1 | Invert vertical sync |
| hsync_o | output | 1 | Horizontal sync, polarity applied |
| vsync_o | output | 1 | Vertical sync, polarity applied |
| de_o | output | 1 | Display enable |
| x_o | output | 16 | Column inside the active window |
| y_o | output | 16 | Row inside the active window |
| sub_o | output | 2 | Byte phase in serial mode |
| pclk_inv_o | output | 1 | Shadowed pixel-clock inversion |

## Verification
All results appear exactly one clock after the counter position they describe. Changes made to the inputs become visible only at the first clock after the frame in progress ends. The bench keeps a reference model of the counters and the shadow registers. Before each edge it computes the expected outputs from the model's pre-edge state, advances the model at the edge, and compares at the following falling edge. It changes inputs only after that comparison, so the shadow load at the frame boundary uses the same values in the model and in the design. Line length, frame length and pulse width are measured from edges seen at the outputs.

// File: rtl/lcd_tgen_pkg.sv
package lcd_tgen_pkg;

  // window slots; bit 0 selects the axis (0 = horizontal, 1 = vertical)
  localparam int NWIN = 4;
  localparam int WIN_HSYNC = 0;
  localparam int WIN_VSYNC = 1;
  localparam int WIN_HACT  = 2;
  localparam int WIN_VACT  = 3;

  typedef struct packed {
    logic serial;
    logic pclk_inv;
    logic hs_inv;
    logic vs_inv;
  } mode_t;

endpackage

// File: rtl/lcd_tgen_shadow.sv
module lcd_tgen_shadow
  import lcd_tgen_pkg::*;
#(
  parameter int CW = 16,
  localparam int RW = 2 * CW
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic [NWIN-1:0][RW-1:0]  win_i,
  input  logic [RW-1:0]            total_i,
  input  mode_t                    mode_i,
  output logic [NWIN-1:0][RW-1:0]  win_q,
  output logic [CW-1:0]            htot_q,
  output logic [CW-1:0]            vtot_q,
  output mode_t                    mode_q
);

  // R9: settings are captured only in reset or on the frame-end edge
  always_ff @(posedge clk) begin
    if (rst || load) begin
      win_q  <= win_i;
      htot_q <= total_i[RW-1:CW];
      vtot_q <= total_i[CW-1:0];
      mode_q <= mode_i;
    end
  end

endmodule

// File: rtl/lcd_tgen_axis.sv
module lcd_tgen_axis #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic [CW-1:0] total,
  output logic [CW-1:0] cnt,
  output logic          wrap
);

  logic [CW:0] next_cnt;

  assign next_cnt = {1'b0, cnt} + {{CW{1'b0}}, 1'b1};
  // R6: wrap after total-1; totals of 0 or 1 wrap every step
  assign wrap     = step && (next_cnt >= {1'b0, total});

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (step)
      cnt <= wrap ? '0 : next_cnt[CW-1:0];
  end

endmodule

// File: rtl/lcd_tgen_win.sv
module lcd_tgen_win #(
  parameter int CW = 16,
  localparam int RW = 2 * CW
) (
  input  logic [CW-1:0] cnt,
  input  logic [RW-1:0] word,
  output logic          hit,
  output logic [CW-1:0] offset
);

  logic [CW-1:0] w_start;
  logic [CW-1:0] w_end;

  // R2: start in the upper half, end in the lower half
  assign w_start = word[RW-1:CW];
  assign w_end   = word[CW-1:0];
  assign hit     = (cnt >= w_start) && (cnt < w_end);
  assign offset  = cnt - w_start;

endmodule

// File: rtl/lcd_tgen_out.sv
module lcd_tgen_out
  import lcd_tgen_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NWIN-1:0] hit,
  input  logic [CW-1:0]   hoff,
  input  logic [CW-1:0]   voff,
  input  logic [1:0]      sub,
  input  mode_t           mode,
  output logic            hsync_o,
  output logic            vsync_o,
  output logic            de_o,
  output logic [CW-1:0]   x_o,
  output logic [CW-1:0]   y_o,
  output logic [1:0]      sub_o,
  output logic            pclk_inv_o
);

  logic de_n;

  assign de_n = hit[WIN_HACT] && hit[WIN_VACT];

  // R10: one register stage between counter position and pins
  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_o    <= 1'b0;
      vsync_o    <= 1'b0;
      de_o       <= 1'b0;
      x_o        <= '0;
      y_o        <= '0;
      sub_o      <= '0;
      pclk_inv_o <= 1'b0;
    end else begin
      hsync_o    <= hit[WIN_HSYNC] ^ mode.hs_inv;
      vsync_o    <= hit[WIN_VSYNC] ^ mode.vs_inv;
      de_o       <= de_n;
      x_o        <= de_n ? hoff : '0;
      y_o        <= de_n ? voff : '0;
      sub_o      <= (de_n && mode.serial) ? sub : 2'd0;
      pclk_inv_o <= mode.pclk_inv;
    end
  end

endmodule

// File: rtl/lcd_tgen_top.sv
module lcd_tgen_top
  import lcd_tgen_pkg::*;
#(
  parameter int CW = 16,
  localparam int RW = 2 * CW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [RW-1:0] hsync_win_i,
  input  logic [RW-1:0] vsync_win_i,
  input  logic [RW-1:0] hact_win_i,
  input  logic [RW-1:0] vact_win_i,
  input  logic [RW-1:0] total_i,
  input  logic          serial_i,
  input  logic          pclk_inv_i,
  input  logic          hsync_inv_i,
  input  logic          vsync_inv_i,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic [CW-1:0] x_o,
  output logic [CW-1:0] y_o,
  output logic [1:0]    sub_o,
  output logic          pclk_inv_o
);

  logic [NWIN-1:0][RW-1:0] win_in;
  logic [NWIN-1:0][RW-1:0] win_q;
  logic [NWIN-1:0][CW-1:0] win_off;
  logic [NWIN-1:0]         win_hit;
  logic [CW-1:0]           htot;
  logic [CW-1:0]           vtot;
  mode_t                   mode_in;
  mode_t                   mode_q;
  logic [CW-1:0]           hcnt;
  logic [CW-1:0]           vcnt;
  logic                    line_end;
  logic                    frame_end;
  logic                    hstep;
  logic                    stretch;
  logic [1:0]              sub;
  logic                    ser_active;

  assign win_in[WIN_HSYNC] = hsync_win_i;
  assign win_in[WIN_VSYNC] = vsync_win_i;
  assign win_in[WIN_HACT]  = hact_win_i;
  assign win_in[WIN_VACT]  = vact_win_i;
  assign mode_in = '{serial: serial_i, pclk_inv: pclk_inv_i,
                     hs_inv: hsync_inv_i, vs_inv: vsync_inv_i};

  lcd_tgen_shadow #(.CW(CW)) u_shadow (
    .clk(clk), .rst(rst), .load(frame_end),
    .win_i(win_in), .total_i(total_i), .mode_i(mode_in),
    .win_q(win_q), .htot_q(htot), .vtot_q(vtot), .mode_q(mode_q)
  );

  // one comparator per window; even slots watch h, odd slots watch v
  for (genvar w = 0; w < NWIN; w++) begin : g_win
    lcd_tgen_win #(.CW(CW)) u_win (
      .cnt((w % 2 == 0) ? hcnt : vcnt),
      .word(win_q[w]),
      .hit(win_hit[w]),
      .offset(win_off[w])
    );
  end

  // R7: in serial mode an active position holds for three clocks
  assign ser_active = mode_q.serial;
  assign stretch    = ser_active && win_hit[WIN_HACT];
  assign hstep      = !stretch || (sub == 2'd2);

  always_ff @(posedge clk) begin
    if (rst || !stretch || hstep)
      sub <= 2'd0;
    else
      sub <= sub + 2'd1;
  end

  lcd_tgen_axis #(.CW(CW)) u_hcnt (
    .clk(clk), .rst(rst), .step(hstep), .total(htot),
    .cnt(hcnt), .wrap(line_end)
  );

  lcd_tgen_axis #(.CW(CW)) u_vcnt (
    .clk(clk), .rst(rst), .step(line_end), .total(vtot),
    .cnt(vcnt), .wrap(frame_end)
  );

  lcd_tgen_out #(.CW(CW)) u_out (
    .clk(clk), .rst(rst), .hit(win_hit),
    .hoff(win_off[WIN_HACT]), .voff(win_off[WIN_VACT]),
    .sub(sub), .mode(mode_q),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
    .x_o(x_o), .y_o(y_o), .sub_o(sub_o), .pclk_inv_o(pclk_inv_o)
  );

endmodule

// File: rtl/lcd_tgen_chk.sv
module lcd_tgen_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          de_o,
  input logic [CW-1:0] x_o,
  input logic [CW-1:0] y_o,
  input logic [1:0]    sub_o,
  input logic          ser
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!de_o && x_o == '0 && y_o == '0 && sub_o == 2'd0));

  // R5
  idle_xy_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !de_o |-> (x_o == '0 && y_o == '0));

  // R5
  x_step_chk: assert property (@(posedge clk) disable iff (rst)
    (de_o && $past(de_o) && !ser && x_o != '0) |->
      (x_o == CW'($past(x_o) + 1'b1) && y_o == $past(y_o)));

  // R7
  sub_range_chk: assert property (@(posedge clk) disable iff (rst)
    sub_o != 2'd3);

  // R7
  sub_order_chk: assert property (@(posedge clk) disable iff (rst)
    (sub_o != 2'd0) |-> (sub_o == 2'($past(sub_o) + 2'd1)));

endmodule

bind lcd_tgen_top lcd_tgen_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .de_o(de_o), .x_o(x_o), .y_o(y_o),
  .sub_o(sub_o), .ser(ser_active)
);

// File: tb/lcd_tgen_top_test.sv
module lcd_tgen_top_test;

  typedef struct packed {
    logic [15:0] htot, vtot, hs_s, hs_e, vs_s, vs_e, ha_s, ha_e, va_s, va_e;
    logic ser, pinv, hinv, vinv;
  } vec_t;

  localparam int NV = 4;
  localparam vec_t TBL [NV] = '{
    '{16'd12, 16'd6, 16'd0, 16'd2, 16'd0, 16'd1, 16'd4, 16'd9, 16'd2, 16'd5, 1'b0, 1'b0, 1'b0, 1'b0},
    '{16'd12, 16'd6, 16'd0, 16'd2, 16'd0, 16'd1, 16'd4, 16'd9, 16'd2, 16'd5, 1'b0, 1'b1, 1'b1, 1'b1},
    '{16'd10, 16'd5, 16'd0, 16'd1, 16'd0, 16'd1, 16'd3, 16'd6, 16'd1, 16'd4, 1'b1, 1'b0, 1'b0, 1'b0},
    '{16'd8,  16'd4, 16'd0, 16'd0, 16'd0, 16'd1, 16'd0, 16'd8, 16'd0, 16'd4, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  vec_t cur;
  vec_t sh;
  logic hsync_o, vsync_o, de_o, pclk_inv_o;
  logic [15:0] x_o, y_o;
  logic [1:0] sub_o;

  int checks = 0;
  int errors = 0;
  int mh = 0, mv = 0, msub = 0;
  int cyc = 0;
  int hs_last = 0, hs_int = 0, hs_rise = 0, hs_w = 0;
  int vs_last = 0, vs_int = 0;
  logic prev_hs = 1'b0, prev_vs = 1'b0;

  always #4 clk = ~clk;

  lcd_tgen_top uut (
    .clk(clk), .rst(rst),
    .hsync_win_i({cur.hs_s, cur.hs_e}), .vsync_win_i({cur.vs_s, cur.vs_e}),
    .hact_win_i({cur.ha_s, cur.ha_e}), .vact_win_i({cur.va_s, cur.va_e}),
    .total_i({cur.htot, cur.vtot}),
    .serial_i(cur.ser), .pclk_inv_i(cur.pinv),
    .hsync_inv_i(cur.hinv), .vsync_inv_i(cur.vinv),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
    .x_o(x_o), .y_o(y_o), .sub_o(sub_o), .pclk_inv_o(pclk_inv_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    logic ehs, evs, ede, epi;
    int ex, ey, esub;
    bit ha, va, st, adv, le;
    if (rst) begin
      ehs = 0; evs = 0; ede = 0; epi = 0; ex = 0; ey = 0; esub = 0;
    end else begin
      ha  = (mh >= sh.ha_s) && (mh < sh.ha_e);
      va  = (mv >= sh.va_s) && (mv < sh.va_e);
      ehs = ((mh >= sh.hs_s) && (mh < sh.hs_e)) ^ sh.hinv;
      evs = ((mv >= sh.vs_s) && (mv < sh.vs_e)) ^ sh.vinv;
      ede = ha && va;
      ex  = ede ? mh - sh.ha_s : 0;
      ey  = ede ? mv - sh.va_s : 0;
      esub = (ede && sh.ser) ? msub : 0;
      epi = sh.pinv;
    end
    @(posedge clk);
    if (rst) begin
      mh = 0; mv = 0; msub = 0; sh = cur;
    end else begin
      st  = sh.ser && (mh >= sh.ha_s) && (mh < sh.ha_e);
      adv = !st || msub == 2;
      msub = (st && !adv) ? msub + 1 : 0;
      le  = adv && (mh + 1 >= sh.htot);
      if (adv) mh = le ? 0 : mh + 1;
      if (le) begin
        if (mv + 1 >= sh.vtot) begin
          mv = 0; sh = cur;   // R9 frame-boundary load
        end else mv = mv + 1;
      end
    end
    @(negedge clk);
    cyc++;
    check(hsync_o == ehs, "R3/R8", "hsync", hsync_o, ehs);
    check(vsync_o == evs, "R4/R8", "vsync", vsync_o, evs);
    check(de_o == ede && x_o == ex && y_o == ey, "R5", "de/x/y",
          {de_o, x_o, y_o}, {ede, ex[15:0], ey[15:0]});
    check(sub_o == esub[1:0], "R7", "sub", sub_o, esub);
    check(pclk_inv_o == epi, "R8", "pclk_inv", pclk_inv_o, epi);
    if (hsync_o && !prev_hs) begin hs_int = cyc - hs_last; hs_last = cyc; hs_rise = cyc; end
    if (!hsync_o && prev_hs) hs_w = cyc - hs_rise;
    if (vsync_o && !prev_vs) begin vs_int = cyc - vs_last; vs_last = cyc; end
    prev_hs = hsync_o;
    prev_vs = vsync_o;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic restart(input vec_t v);
    cur = v;
    rst = 1'b1;
    run(2);
    rst = 1'b0;
  endtask

  initial begin
    cur = TBL[0];
    sh  = TBL[0];
    run(3);
    // R1: outputs held clear under reset
    check(!hsync_o && !vsync_o && !de_o && x_o == 0 && y_o == 0 && sub_o == 0 && !pclk_inv_o,
          "R1", "reset outputs", {hsync_o, vsync_o, de_o}, 0);

    for (int e = 0; e < NV; e++) begin
      restart(TBL[e]);
      tick();
      // R10: first edge after reset shows position (0,0)
      check(hsync_o == (TBL[e].hs_e != 0) ^ TBL[e].hinv, "R10", "first hsync",
            hsync_o, (TBL[e].hs_e != 0) ^ TBL[e].hinv);
      run(200);
    end

    // R6: line and frame lengths from sync edges
    restart(TBL[0]);
    run(160);
    check(hs_int == 12, "R6", "line length", hs_int, 12);
    check(vs_int == 72, "R6", "frame length", vs_int, 72);

    // R7: serial line stretched by 2 x width
    restart(TBL[2]);
    run(50);
    check(hs_int == 16, "R7", "serial line length", hs_int, 16);

    // R9: mid-frame change applies from next frame only
    restart(TBL[0]);
    run(30);
    cur.hs_e = 16'd5;
    run(30);
    check(hs_w == 2, "R9", "hsync width same frame", hs_w, 2);
    run(60);
    check(hs_w == 5, "R9", "hsync width next frame", hs_w, 5);

    // R2/R3: empty window never fires (start == end)
    restart(TBL[3]);
    run(20);
    check(hs_w == 5 && !hsync_o, "R2", "empty hsync window", hsync_o, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule